// File: doc/BRIEF.md
# Merged-Tree Signed Multiply-Accumulate Unit

This block is the arithmetic core of a digital filter kernel. On each cycle in which `in_valid` is high it takes two signed 16-bit operands and adds their product to a 32-bit running sum. The product is never formed on its own. The multiplier is recoded into radix-4 Booth rows, and the fed-back accumulator value joins those rows as one more addend. A carry-save compression tree reduces all the rows to two vectors, and one carry-propagate adder finishes the sum. The multiplier and the accumulation therefore share a single adder.

A two-state controller decides what goes into the feedback row. In `ST_EMPTY` no sum is open and the feedback row is zero. In `ST_SUM` the feedback row carries the register value. The transitions are:
- `ST_EMPTY → ST_SUM` on any accepted operand pair.
- `ST_SUM → ST_EMPTY` on a clear with no operands.
- `ST_SUM → ST_SUM` on an accepted pair, whether or not clear is also high. A pair accepted together with clear restarts the sum from zero.

Two mode inputs condition the result. The saturation input clamps the accumulator on signed overflow. The rounding input selects how the 16-bit result is taken from the accumulator, and that result is clamped as well when saturation is on.

Top module: `mac_merged_tree`

## Requirements
- R1: When `in_valid` and `clr` are both high at a clock edge, `acc_out` after that edge equals the signed product `op_a*op_b`, and `ovf_flag` is 0.
- R2: When `in_valid` is high and `clr` is low, `acc_out` after the edge equals the previous `acc_out` plus `op_a*op_b`.
- R3: A clear with `in_valid` low sets `acc_out` to 0 and `ovf_flag` to 0, and returns the controller to `ST_EMPTY`. Reset gives the same state.
- R4: With `in_valid` and `clr` both low, `acc_out` and `ovf_flag` keep their values.
- R5: With `sat_en` high, a sum above 2^31-1 loads 0x7FFFFFFF, a sum below -2^31 loads 0x80000000, and in both cases `ovf_flag` is set.
- R6: With `sat_en` low, an overflowing sum wraps modulo 2^32 and does not set `ovf_flag`.
- R7: Once set, `ovf_flag` stays high until a clear, including across later operations in either mode.
- R8: With `rnd_en` low, the result is truncated: `res_out` is bits [30:15] of `acc_out`, which is floor(acc/2^15) kept to 16 bits.
- R9: With `rnd_en` high, `res_out` is floor((acc + 2^14)/2^15), that is, round half up.
- R10: With `sat_en` high, a shifted (and rounded) value above 32767 gives 0x7FFF, and one below -32768 gives 0x8000.
- R11: `out_valid` is high in exactly the cycle after each accepted pair. `acc_out` is updated at that same edge.
- R12: The extreme product -32768 × -32768 = 0x40000000 is formed exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on `op_a`/`op_b` is accepted this cycle |
| clr | input | 1 | Start a new sum (zero the feedback row; alone, zero the register) |
| sat_en | input | 1 | Clamp on overflow, both the accumulator and the 16-bit result |
| rnd_en | input | 1 | 1: round half up; 0: truncate |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier (Booth-recoded) |
| acc_out | output | 32 | Accumulator register |
| res_out | output | 16 | Rounded/saturated result from `acc_out` |
| ovf_flag | output | 1 | Sticky saturation flag |
| out_valid | output | 1 | `acc_out` holds a new value this cycle |

## Verification
The bench drives the accumulator across both signed limits with `sat_en` high and with it low. A design that clamps to the wrong constant, clamps when it should wrap, or never sets the sticky flag shows up on `acc_out` and `ovf_flag`. The operand -32768 × -32768 and long runs of mixed-sign pseudo-random pairs target Booth rows with a wrong negation or correction bit, which would give products that are off by small multiples of 4^i. The rounding cases sit exactly on the half-way point for both signs, where a round-to-zero or round-half-away design returns a different 16-bit result. Restart-with-operands and clear-alone are also exercised, to catch a feedback row that leaks the old sum into a new one.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_SUM   = 1'b1
    } mac_state_e;

    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_dig_t;
endpackage

// File: rtl/mac_booth_rows.sv
module mac_booth_rows #(
    parameter int OP_W   = 16,
    parameter int TREE_W = 34,
    localparam int DIGITS = OP_W / 2
) (
    input  logic [OP_W-1:0]                 mcand,
    input  logic [OP_W-1:0]                 mplier,
    output logic [DIGITS-1:0][TREE_W-1:0]   rows,
    output logic [TREE_W-1:0]               corr
);
    import mac_pkg::*;

    logic [TREE_W-1:0] mcand_ext;
    logic [DIGITS-1:0] neg_bits;

    assign mcand_ext = {{(TREE_W-OP_W){mcand[OP_W-1]}}, mcand};

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        logic [2:0]        trip;
        booth_dig_t        dig;
        logic [TREE_W-1:0] mag;

        if (d == 0) begin : g_first
            assign trip = {mplier[1], mplier[0], 1'b0};
        end else begin : g_rest
            assign trip = {mplier[2*d+1], mplier[2*d], mplier[2*d-1]};
        end

        always_comb begin
            dig.neg = trip[2];
            dig.one = trip[1] ^ trip[0];
            dig.two = (trip == 3'b100) || (trip == 3'b011);
            if (dig.one)      mag = mcand_ext;
            else if (dig.two) mag = mcand_ext << 1;
            else              mag = '0;
            rows[d] = (dig.neg ? ~mag : mag) << (2*d);
        end

        assign neg_bits[d] = dig.neg;
    end

    always_comb begin
        corr = '0;
        for (int d = 0; d < DIGITS; d++) begin
            corr[2*d] = neg_bits[d];
        end
    end
endmodule

// File: rtl/mac_csa_tree.sv
module mac_csa_tree #(
    parameter int ROWS = 10,
    parameter int W    = 34
) (
    input  logic [ROWS-1:0][W-1:0] rows_in,
    output logic [W-1:0]           vec_s,
    output logic [W-1:0]           vec_c
);
    logic [W-1:0] cur [ROWS];
    logic [W-1:0] nxt [ROWS];
    int           live;
    int           put;

    always_comb begin
        for (int k = 0; k < ROWS; k++) cur[k] = rows_in[k];
        for (int k = 0; k < ROWS; k++) nxt[k] = '0;
        live = ROWS;
        put  = 0;
        for (int lvl = 0; lvl < ROWS; lvl++) begin
            if (live > 2) begin
                for (int k = 0; k < ROWS; k++) nxt[k] = '0;
                put = 0;
                for (int g = 0; g < ROWS / 3; g++) begin
                    if (3*g + 2 < live) begin
                        nxt[put]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
                        nxt[put+1] = ((cur[3*g] & cur[3*g+1]) |
                                      (cur[3*g] & cur[3*g+2]) |
                                      (cur[3*g+1] & cur[3*g+2])) << 1;
                        put = put + 2;
                    end
                end
                for (int k = 0; k < ROWS; k++) begin
                    if (k >= 3*(live/3) && k < live) begin
                        nxt[put] = cur[k];
                        put = put + 1;
                    end
                end
                for (int k = 0; k < ROWS; k++) cur[k] = nxt[k];
                live = put;
            end
        end
        vec_s = cur[0];
        vec_c = (live > 1) ? cur[1] : '0;
    end
endmodule

// File: rtl/mac_round_sat.sv
module mac_round_sat #(
    parameter int ACC_W   = 32,
    parameter int OUT_W   = 16,
    parameter int RND_LSB = 15,
    localparam int HI_W   = ACC_W - RND_LSB + 1
) (
    input  logic [HI_W-1:0]  acc_hi,
    input  logic             rnd_en,
    input  logic             sat_en,
    output logic [OUT_W-1:0] res
);
    logic [HI_W-1:0] wide;

    assign wide = {acc_hi[HI_W-1], acc_hi[HI_W-1:1]} +
                  {{(HI_W-1){1'b0}}, rnd_en & acc_hi[0]};

    if (HI_W > OUT_W) begin : g_clamp
        logic too_hi;
        logic too_lo;
        always_comb begin
            too_hi = !wide[HI_W-1] && (|wide[HI_W-2:OUT_W-1]);
            too_lo =  wide[HI_W-1] && !(&wide[HI_W-2:OUT_W-1]);
            if (sat_en && too_hi)      res = {1'b0, {(OUT_W-1){1'b1}}};
            else if (sat_en && too_lo) res = {1'b1, {(OUT_W-1){1'b0}}};
            else                       res = wide[OUT_W-1:0];
        end
    end else begin : g_pass
        logic unused_sat;
        assign unused_sat = sat_en;
        assign res = {{(OUT_W-HI_W){wide[HI_W-1]}}, wide};
    end
endmodule

// File: rtl/mac_merged_tree.sv
module mac_merged_tree #(
    parameter int OP_W    = 16,
    parameter int ACC_W   = 32,
    parameter int OUT_W   = 16,
    parameter int RND_LSB = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             clr,
    input  logic             sat_en,
    input  logic             rnd_en,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic [ACC_W-1:0] acc_out,
    output logic [OUT_W-1:0] res_out,
    output logic             ovf_flag,
    output logic             out_valid
);
    import mac_pkg::*;

    localparam int DIGITS = OP_W / 2;
    localparam int TREE_W = ACC_W + 2;
    localparam int ROWS   = DIGITS + 2;

    mac_state_e state_q, state_d;

    logic [ACC_W-1:0]              acc_q, acc_d;
    logic                          flag_q, flag_d;
    logic                          vld_q;
    logic [DIGITS-1:0][TREE_W-1:0] pp_rows;
    logic [TREE_W-1:0]             corr_row;
    logic [TREE_W-1:0]             fb_row;
    logic [ROWS-1:0][TREE_W-1:0]   all_rows;
    logic [TREE_W-1:0]             vec_s, vec_c, tree_sum;
    logic [ACC_W+1:ACC_W-1]        top_bits;
    logic                          sum_ovf;
    logic [ACC_W-1:0]              clamp_val;

    mac_booth_rows #(.OP_W(OP_W), .TREE_W(TREE_W)) u_rows (
        .mcand (op_a),
        .mplier(op_b),
        .rows  (pp_rows),
        .corr  (corr_row)
    );

    // feedback row: zero when starting a new sum
    assign fb_row = (clr || state_q == ST_EMPTY) ? '0
                  : {{(TREE_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
    assign all_rows = {fb_row, corr_row, pp_rows};

    mac_csa_tree #(.ROWS(ROWS), .W(TREE_W)) u_tree (
        .rows_in(all_rows),
        .vec_s  (vec_s),
        .vec_c  (vec_c)
    );

    assign tree_sum  = vec_s + vec_c;
    assign top_bits  = tree_sum[ACC_W+1:ACC_W-1];
    assign sum_ovf   = (|top_bits) && !(&top_bits);
    assign clamp_val = tree_sum[TREE_W-1] ? {1'b1, {(ACC_W-1){1'b0}}}
                                          : {1'b0, {(ACC_W-1){1'b1}}};

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)         state_d = ST_SUM;
            ST_SUM:   if (clr && !in_valid) state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // datapath next values
    always_comb begin
        acc_d  = acc_q;
        flag_d = flag_q;
        if (in_valid) begin
            flag_d = clr ? 1'b0 : flag_q;
            if (sum_ovf && sat_en) begin
                acc_d  = clamp_val;
                flag_d = 1'b1;
            end else begin
                acc_d = tree_sum[ACC_W-1:0];
            end
        end else if (clr) begin
            acc_d  = '0;
            flag_d = 1'b0;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            flag_q <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            flag_q <= flag_d;
            vld_q  <= in_valid;
        end
    end

    mac_round_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .RND_LSB(RND_LSB)) u_rs (
        .acc_hi(acc_q[ACC_W-1:RND_LSB-1]),
        .rnd_en(rnd_en),
        .sat_en(sat_en),
        .res   (res_out)
    );

    assign acc_out   = acc_q;
    assign ovf_flag  = flag_q;
    assign out_valid = vld_q;

    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clr) |=> ($stable(acc_out) && $stable(ovf_flag)));
    assert_clear_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !in_valid) |=> (acc_out == '0 && !ovf_flag && state_q == ST_EMPTY));
    assert_empty_is_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) |-> (acc_q == '0));
    assert_sticky_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr) |=> ovf_flag);
    assert_flag_needs_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(sat_en && in_valid));
endmodule

// File: tb/mac_merged_tree_test.sv
module mac_merged_tree_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        clr = 1'b0;
    logic        sat_en = 1'b0;
    logic        rnd_en = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [31:0] acc_out;
    logic [15:0] res_out;
    logic        ovf_flag;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] acc;
        logic        flag;
        logic [15:0] res;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    longint      m_acc = 0;
    bit          m_flag = 0;
    logic [31:0] lfsr = 32'h1ACE_5EED;

    always #10 clk = ~clk;

    mac_merged_tree uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clr(clr),
        .sat_en(sat_en), .rnd_en(rnd_en), .op_a(op_a), .op_b(op_b),
        .acc_out(acc_out), .res_out(res_out), .ovf_flag(ovf_flag),
        .out_valid(out_valid)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [15:0] model_res(input longint acc, input bit rnd, input bit sat);
        longint w;
        w = (acc + (rnd ? 64'sd16384 : 64'sd0)) >>> 15;
        if (sat && w > 32767)  w = 32767;
        if (sat && w < -32768) w = -32768;
        return w[15:0];
    endfunction

    // driver: one accepted pair, expected result pushed to the scoreboard
    task automatic op(input int a, input int b, input bit c, input bit s,
                      input bit r, input string tag);
        longint sum;
        exp_t   e;
        @(negedge clk);
        in_valid = 1'b1; clr = c; sat_en = s; rnd_en = r;
        op_a = a[15:0]; op_b = b[15:0];
        if (c) m_flag = 0;
        sum = (c ? 64'sd0 : m_acc) + longint'(a) * longint'(b);
        if (sum > 64'sd2147483647 || sum < -64'sd2147483648) begin
            if (s) begin
                m_acc  = (sum > 0) ? 64'sd2147483647 : -64'sd2147483648;
                m_flag = 1;
            end else begin
                m_acc = longint'(int'(sum[31:0]));
            end
        end else begin
            m_acc = sum;
        end
        e.acc = m_acc[31:0];
        e.flag = m_flag;
        e.res = model_res(m_acc, r, s);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0; clr = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_only();
        @(negedge clk);
        in_valid = 1'b0; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m_acc = 0; m_flag = 0;
        check(acc_out == 32'h0, "R3", "acc after clear", acc_out, 0);
        check(ovf_flag == 1'b0, "R3", "flag after clear", ovf_flag, 0);
    endtask

    // monitor: compare each result against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && out_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R11", "out_valid with nothing pending", 1, 0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(acc_out == e.acc, t, "acc_out", acc_out, e.acc);
                    check(ovf_flag == e.flag, t, "ovf_flag", ovf_flag, e.flag);
                    check(res_out == e.res, t, "res_out", res_out, e.res);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(acc_out == 0 && ovf_flag == 0, "R3", "reset state", acc_out, 0);
        check(out_valid == 0, "R11", "valid in reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R12: basic accumulation
        op(3, 4, 1, 0, 0, "R1");
        op(-5, 7, 0, 0, 0, "R2");
        op(-32768, -32768, 0, 0, 0, "R12");
        op(1234, -4321, 0, 0, 0, "R2");
        op(-32768, -32768, 1, 0, 0, "R12");
        op(32767, -32768, 1, 0, 0, "R1");

        // R4: hold while idle
        begin
            logic [31:0] held;
            idle(1);
            held = acc_out;
            repeat (3) @(negedge clk);
            check(acc_out == held, "R4", "acc held idle", acc_out, held);
            check(out_valid == 0, "R11", "no valid when idle", out_valid, 0);
        end

        clear_only();

        // R5 R7 R10: positive saturation
        op(-32768, -32768, 1, 1, 0, "R5");
        op(-32768, -32768, 0, 1, 0, "R5");
        op(0, 0, 0, 1, 0, "R7");
        op(-32768, 32767, 0, 0, 0, "R7");
        op(0, 0, 0, 1, 1, "R10");

        // R5 R10: negative saturation
        op(-32768, 32767, 1, 1, 0, "R5");
        op(-32768, 32767, 0, 1, 0, "R5");
        op(-32768, 32767, 0, 1, 0, "R5");
        op(0, 0, 0, 1, 1, "R10");

        // R6: wrap without saturation
        op(-32768, -32768, 1, 0, 0, "R6");
        op(-32768, -32768, 0, 0, 0, "R6");
        op(-32768, -32768, 0, 0, 0, "R6");

        // R8 R9: rounding on the half-way point
        op(1, 16384, 1, 0, 0, "R8");
        op(0, 0, 0, 0, 1, "R9");
        op(1, 16383, 1, 0, 1, "R9");
        op(-1, 16384, 1, 0, 1, "R9");
        op(0, 0, 0, 0, 0, "R8");
        op(3, 32767, 1, 0, 0, "R8");

        idle(2);
        clear_only();

        // R1 R2: mixed-sign pseudo-random stream
        for (int i = 0; i < 200; i++) begin
            int a;
            int b;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            a = int'($signed(lfsr[15:0]));
            b = int'($signed(lfsr[31:16]));
            op(a, b, (i % 17) == 0, lfsr[3], lfsr[7], (i % 17) == 0 ? "R1" : "R2");
        end

        idle(4);
        check(exp_q.size() == 0, "R11", "results outstanding", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule